// File: doc/BRIEF.md
# Binary Convolution Layer Sequencer

This block is the control core of a binary convolution engine. It accepts one layer instruction word and then runs through every output pixel and every 64-channel output group of that layer. The arithmetic, the memories and the binarizing logic sit outside the block and are driven by phase commands. For each (pixel, group) pair the sequencer requests these phases in turn: accumulator clear, convolution sum, an optional residual sum, normalization parameter fetch, binarize and store.

Each phase is a request that the datapath acknowledges. While a phase is requested, the current pixel index, group index and the decoded layer settings are held steady on the outputs. After the last pair the sequencer requests a swap of the input and output buffers, and then it raises a completion pulse.

Loop bounds come from log2-coded fields of the instruction. The output side length is the input side length divided by the first stride. The group count is the output channel count divided by 64.

Top module: `bconv_layer_seq`

## Requirements
- R1: The instruction word has these fields, least significant first: opcode [1:0], kernel size [5:2], log2 input side [8:6], log2 input channels [12:9], log2 output channels [16:13], first stride [18:17], second stride [20:19], weight base [36:21], normalization base [52:37]. The word is taken on a clock edge where `start_i` is high and `busy_o` is low. From the next cycle, `busy_o`, `req_o` and phase CLEAR are asserted. For the whole layer, `ksize_o`, `s1_o`, `s2_o` and `wbase_o` show their fields and `in_ch_o` shows 1 << (log2 input channels).
- R2: A start pulse that arrives while `busy_o` is high is ignored. The running layer's settings, phase order and loop counts do not change.
- R3: Phase codes are CLEAR=0, CONV=1, RESID=2, NORM=3, BIN=4, STORE=5, SWAP=6. For every (pixel, group) pair the order is CLEAR, CONV, [RESID], NORM, BIN, STORE.
- R4: RESID is issued after CONV only when the opcode is 2'b01. Any other opcode goes straight from CONV to NORM.
- R5: `req_o` and `phase_o` stay unchanged until a cycle with `ack_i` high. The following phase is requested in the very next cycle.
- R6: The pixel loop is outer and the group loop is inner. `pix_o` counts from 0 to D*D-1, where D = (1 << log2 input side) / stride1. A stride field of 0 acts as 1, and a quotient of 0 acts as 1.
- R7: `grp_o` counts from 0 up to 2^(log2 output channels − 6) − 1. When log2 output channels is below 6, exactly one group is run.
- R8: During NORM, `bn_addr_o` equals the normalization base plus the group index.
- R9: After the STORE of the last pair, SWAP is requested. One cycle after SWAP is acknowledged, `done_o` is high for exactly one cycle, and in that cycle `busy_o` and `req_o` are already low.
- R10: Reset is synchronous and active high. It leaves `busy_o`, `req_o` and `done_o` low, including when it arrives in the middle of a layer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for a new layer |
| instr_i | input | 53 | Layer instruction word |
| ack_i | input | 1 | Datapath acknowledge of the current phase |
| busy_o | output | 1 | Layer in progress |
| req_o | output | 1 | Phase request |
| phase_o | output | 3 | Requested phase code |
| done_o | output | 1 | One-cycle layer completion pulse |
| pix_o | output | 16 | Current output pixel index |
| grp_o | output | 10 | Current output channel group |
| ksize_o | output | 4 | Kernel size field |
| in_ch_o | output | 16 | Input channel count |
| s1_o | output | 2 | First stride field |
| s2_o | output | 2 | Second stride field |
| wbase_o | output | 16 | Weight base address |
| bn_addr_o | output | 16 | Normalization parameter address |

## Verification
A wrong phase register shows up at the next acknowledged handshake. It appears as an out-of-order or missing code on `phase_o`, and a residual pass that was wrongly taken or skipped is visible within one pair. A wrong loop counter or a wrong decoded bound shows on `pix_o` or `grp_o` at the first CLEAR after the faulty step, or as a SWAP that comes early or late at the end of the layer. Config registers that are corrupted by an ignored start appear on the config outputs in the cycle after that start.

// File: rtl/bcls_pkg.sv
package bcls_pkg;

  typedef enum logic [2:0] {
    PH_CLEAR = 3'd0,
    PH_CONV  = 3'd1,
    PH_RESID = 3'd2,
    PH_NORM  = 3'd3,
    PH_BIN   = 3'd4,
    PH_STORE = 3'd5,
    PH_SWAP  = 3'd6
  } phase_e;

  localparam logic [1:0] OPC_RESID = 2'b01;
  localparam int GROUP_LOG = 6;

endpackage

// File: rtl/bcls_decode.sv
module bcls_decode #(
  parameter int ADDR_W   = 16,
  parameter int KS_W     = 4,
  parameter int HW_LOG_W = 3,
  parameter int IC_LOG_W = 4,
  parameter int OC_LOG_W = 4,
  parameter int STR_W    = 2,
  localparam int INSTR_W  = 2 + KS_W + HW_LOG_W + IC_LOG_W + OC_LOG_W + 2*STR_W + 2*ADDR_W,
  localparam int DIM_W    = 1 << HW_LOG_W,
  localparam int IC_CNT_W = 1 << IC_LOG_W,
  localparam int GRP_W    = ((1 << OC_LOG_W) > bcls_pkg::GROUP_LOG) ?
                            (1 << OC_LOG_W) - bcls_pkg::GROUP_LOG : 1
) (
  input  logic [INSTR_W-1:0]  instr,
  output logic [1:0]          op,
  output logic [KS_W-1:0]     ks,
  output logic [IC_CNT_W-1:0] ic_cnt,
  output logic [STR_W-1:0]    s1,
  output logic [STR_W-1:0]    s2,
  output logic [ADDR_W-1:0]   wbase,
  output logic [ADDR_W-1:0]   bnbase,
  output logic [DIM_W-1:0]    dim,
  output logic [GRP_W-1:0]    grp_cnt
);
  import bcls_pkg::*;

  localparam int P_KS = 2;
  localparam int P_HW = P_KS + KS_W;
  localparam int P_IC = P_HW + HW_LOG_W;
  localparam int P_OC = P_IC + IC_LOG_W;
  localparam int P_S1 = P_OC + OC_LOG_W;
  localparam int P_S2 = P_S1 + STR_W;
  localparam int P_WB = P_S2 + STR_W;
  localparam int P_BB = P_WB + ADDR_W;
  localparam logic [OC_LOG_W-1:0] GL = OC_LOG_W'(GROUP_LOG);

  logic [HW_LOG_W-1:0] hw_log;
  logic [IC_LOG_W-1:0] ic_log;
  logic [OC_LOG_W-1:0] oc_log;
  logic [DIM_W-1:0]    side;
  logic [DIM_W-1:0]    stride;
  logic [DIM_W-1:0]    quot;

  always_comb begin
    op     = instr[1:0];
    ks     = instr[P_KS +: KS_W];
    hw_log = instr[P_HW +: HW_LOG_W];
    ic_log = instr[P_IC +: IC_LOG_W];
    oc_log = instr[P_OC +: OC_LOG_W];
    s1     = instr[P_S1 +: STR_W];
    s2     = instr[P_S2 +: STR_W];
    wbase  = instr[P_WB +: ADDR_W];
    bnbase = instr[P_BB +: ADDR_W];

    ic_cnt = IC_CNT_W'(1) << ic_log;
    side   = DIM_W'(1) << hw_log;
    stride = (s1 == '0) ? DIM_W'(1) : DIM_W'(s1);
    quot   = side / stride;
    dim    = (quot == '0) ? DIM_W'(1) : quot;

    if (oc_log < GL) grp_cnt = GRP_W'(1);
    else             grp_cnt = GRP_W'(1) << (oc_log - GL);
  end

endmodule

// File: rtl/bcls_loop_ctr.sv
module bcls_loop_ctr #(
  parameter int DIM_W = 8,
  parameter int GRP_W = 10,
  localparam int PIX_W = 2 * DIM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic [DIM_W-1:0] dim,
  input  logic [GRP_W-1:0] grp_cnt,
  output logic [PIX_W-1:0] pix,
  output logic [GRP_W-1:0] grp,
  output logic             last
);

  logic [DIM_W-1:0] col;
  logic [DIM_W-1:0] row;
  logic             grp_end;
  logic             col_end;
  logic             row_end;

  always_comb begin
    grp_end = (grp == grp_cnt - GRP_W'(1));
    col_end = (col == dim - DIM_W'(1));
    row_end = (row == dim - DIM_W'(1));
    last    = grp_end && col_end && row_end;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      col <= '0;
      row <= '0;
      pix <= '0;
      grp <= '0;
    end else if (step) begin
      if (grp_end) begin
        grp <= '0;
        pix <= pix + PIX_W'(1);
        if (col_end) begin
          col <= '0;
          row <= row + DIM_W'(1);
        end else begin
          col <= col + DIM_W'(1);
        end
      end else begin
        grp <= grp + GRP_W'(1);
      end
    end
  end

endmodule

// File: rtl/bcls_phase_fsm.sv
module bcls_phase_fsm (
  input  logic                clk,
  input  logic                rst,
  input  logic                accept,
  input  logic                ack,
  input  logic                resid_en,
  input  logic                last_pair,
  output logic                req,
  output bcls_pkg::phase_e    phase,
  output logic                busy,
  output logic                done,
  output logic                step
);
  import bcls_pkg::*;

  logic fire;

  always_comb begin
    fire = req && ack;
    step = fire && (phase == PH_STORE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req   <= 1'b0;
      phase <= PH_CLEAR;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        req   <= 1'b1;
        phase <= PH_CLEAR;
      end else if (fire) begin
        unique case (phase)
          PH_CLEAR: phase <= PH_CONV;
          PH_CONV:  phase <= resid_en ? PH_RESID : PH_NORM;
          PH_RESID: phase <= PH_NORM;
          PH_NORM:  phase <= PH_BIN;
          PH_BIN:   phase <= PH_STORE;
          PH_STORE: phase <= last_pair ? PH_SWAP : PH_CLEAR;
          PH_SWAP: begin
            req   <= 1'b0;
            busy  <= 1'b0;
            done  <= 1'b1;
            phase <= PH_CLEAR;
          end
          default:  phase <= PH_CLEAR;
        endcase
      end
    end
  end

endmodule

// File: rtl/bconv_layer_seq.sv
module bconv_layer_seq #(
  parameter int ADDR_W   = 16,
  parameter int KS_W     = 4,
  parameter int HW_LOG_W = 3,
  parameter int IC_LOG_W = 4,
  parameter int OC_LOG_W = 4,
  parameter int STR_W    = 2,
  localparam int INSTR_W  = 2 + KS_W + HW_LOG_W + IC_LOG_W + OC_LOG_W + 2*STR_W + 2*ADDR_W,
  localparam int DIM_W    = 1 << HW_LOG_W,
  localparam int PIX_W    = 2 * DIM_W,
  localparam int IC_CNT_W = 1 << IC_LOG_W,
  localparam int GRP_W    = ((1 << OC_LOG_W) > bcls_pkg::GROUP_LOG) ?
                            (1 << OC_LOG_W) - bcls_pkg::GROUP_LOG : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [INSTR_W-1:0]  instr_i,
  input  logic                ack_i,
  output logic                busy_o,
  output logic                req_o,
  output logic [2:0]          phase_o,
  output logic                done_o,
  output logic [PIX_W-1:0]    pix_o,
  output logic [GRP_W-1:0]    grp_o,
  output logic [KS_W-1:0]     ksize_o,
  output logic [IC_CNT_W-1:0] in_ch_o,
  output logic [STR_W-1:0]    s1_o,
  output logic [STR_W-1:0]    s2_o,
  output logic [ADDR_W-1:0]   wbase_o,
  output logic [ADDR_W-1:0]   bn_addr_o
);
  import bcls_pkg::*;

  logic [1:0]          d_op;
  logic [KS_W-1:0]     d_ks;
  logic [IC_CNT_W-1:0] d_ic;
  logic [STR_W-1:0]    d_s1;
  logic [STR_W-1:0]    d_s2;
  logic [ADDR_W-1:0]   d_wb;
  logic [ADDR_W-1:0]   d_bb;
  logic [DIM_W-1:0]    d_dim;
  logic [GRP_W-1:0]    d_gc;

  logic [1:0]          op_q;
  logic [ADDR_W-1:0]   bb_q;
  logic [DIM_W-1:0]    dim_q;
  logic [GRP_W-1:0]    gc_q;

  logic    accept;
  logic    last_pair;
  logic    step;
  phase_e  phase;

  bcls_decode #(
    .ADDR_W(ADDR_W), .KS_W(KS_W), .HW_LOG_W(HW_LOG_W),
    .IC_LOG_W(IC_LOG_W), .OC_LOG_W(OC_LOG_W), .STR_W(STR_W)
  ) i_decode (
    .instr(instr_i), .op(d_op), .ks(d_ks), .ic_cnt(d_ic), .s1(d_s1), .s2(d_s2),
    .wbase(d_wb), .bnbase(d_bb), .dim(d_dim), .grp_cnt(d_gc)
  );

  assign accept = start_i && !busy_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= '0;
      ksize_o <= '0;
      in_ch_o <= '0;
      s1_o    <= '0;
      s2_o    <= '0;
      wbase_o <= '0;
      bb_q    <= '0;
      dim_q   <= DIM_W'(1);
      gc_q    <= GRP_W'(1);
    end else if (accept) begin
      op_q    <= d_op;
      ksize_o <= d_ks;
      in_ch_o <= d_ic;
      s1_o    <= d_s1;
      s2_o    <= d_s2;
      wbase_o <= d_wb;
      bb_q    <= d_bb;
      dim_q   <= d_dim;
      gc_q    <= d_gc;
    end
  end

  bcls_loop_ctr #(.DIM_W(DIM_W), .GRP_W(GRP_W)) i_loop (
    .clk(clk), .rst(rst), .clear(accept), .step(step),
    .dim(dim_q), .grp_cnt(gc_q), .pix(pix_o), .grp(grp_o), .last(last_pair)
  );

  bcls_phase_fsm i_fsm (
    .clk(clk), .rst(rst), .accept(accept), .ack(ack_i),
    .resid_en(op_q == OPC_RESID), .last_pair(last_pair),
    .req(req_o), .phase(phase), .busy(busy_o), .done(done_o), .step(step)
  );

  assign phase_o   = phase;
  assign bn_addr_o = bb_q + ADDR_W'(grp_o);

endmodule

// File: rtl/bcls_checker.sv
module bcls_checker (
  input logic        clk,
  input logic        rst,
  input logic        start_i,
  input logic        ack_i,
  input logic        req_o,
  input logic [2:0]  phase_o,
  input logic        busy_o,
  input logic        done_o,
  input logic [15:0] pix_o,
  input logic [15:0] wbase_o,
  input logic [1:0]  op_q
);
  import bcls_pkg::*;

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
    req_o && !ack_i |=> req_o && $stable(phase_o));

  assert_req_busy_R5: assert property (@(posedge clk) disable iff (rst)
    req_o |-> busy_o);

  assert_pix_hold_R6: assert property (@(posedge clk) disable iff (rst)
    req_o && !ack_i |=> $stable(pix_o));

  assert_phase_legal_R3: assert property (@(posedge clk) disable iff (rst)
    req_o |-> phase_o <= 3'(PH_SWAP));

  assert_resid_gate_R4: assert property (@(posedge clk) disable iff (rst)
    req_o && phase_o == 3'(PH_RESID) |-> op_q == OPC_RESID);

  assert_busy_start_R2: assert property (@(posedge clk) disable iff (rst)
    busy_o && start_i |=> $stable(wbase_o));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o && !req_o);

  assert_done_after_swap_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(req_o && ack_i && phase_o == 3'(PH_SWAP)));

endmodule

bind bconv_layer_seq bcls_checker i_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .ack_i(ack_i), .req_o(req_o),
  .phase_o(phase_o), .busy_o(busy_o), .done_o(done_o), .pix_o(pix_o),
  .wbase_o(wbase_o), .op_q(op_q)
);

// File: tb/test_bconv_layer_seq.sv
`timescale 1ns/1ps
module test_bconv_layer_seq;
  import bcls_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [52:0] instr_i = '0;
  logic        ack_i = 1'b0;
  logic        busy_o, req_o, done_o;
  logic [2:0]  phase_o;
  logic [15:0] pix_o, in_ch_o, wbase_o, bn_addr_o;
  logic [9:0]  grp_o;
  logic [3:0]  ksize_o;
  logic [1:0]  s1_o, s2_o;

  always #4 clk = ~clk;

  bconv_layer_seq i_bconv_layer_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .instr_i(instr_i), .ack_i(ack_i),
    .busy_o(busy_o), .req_o(req_o), .phase_o(phase_o), .done_o(done_o),
    .pix_o(pix_o), .grp_o(grp_o), .ksize_o(ksize_o), .in_ch_o(in_ch_o),
    .s1_o(s1_o), .s2_o(s2_o), .wbase_o(wbase_o), .bn_addr_o(bn_addr_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  ks;
    logic [2:0]  hw;
    logic [3:0]  ic;
    logic [3:0]  oc;
    logic [1:0]  s1;
    logic [1:0]  s2;
    logic [15:0] wb;
    logic [15:0] bb;
    logic [3:0]  dly;
    logic        bst;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TBL [NV] = '{
    '{2'b01, 4'd3, 3'd1, 4'd5, 4'd6, 2'd1, 2'd1, 16'h0100, 16'h0040, 4'd0, 1'b0},
    '{2'b00, 4'd1, 3'd2, 4'd7, 4'd7, 2'd2, 2'd1, 16'h1234, 16'h0200, 4'd1, 1'b0},
    '{2'b10, 4'd5, 3'd1, 4'd2, 4'd3, 2'd3, 2'd2, 16'h0F00, 16'hFFFE, 4'd0, 1'b0},
    '{2'b11, 4'd3, 3'd2, 4'd9, 4'd8, 2'd1, 2'd3, 16'h4000, 16'h0800, 4'd0, 1'b0},
    '{2'b01, 4'd7, 3'd0, 4'd15, 4'd6, 2'd0, 2'd0, 16'hABCD, 16'h0010, 4'd2, 1'b1},
    '{2'b00, 4'd1, 3'd3, 4'd4, 4'd6, 2'd3, 2'd2, 16'h0001, 16'h0300, 4'd0, 1'b0}
  };

  // One handshake: check request, phase, loop indices and held settings, then acknowledge.
  task automatic handshake(vec_t v, phase_e ph, int p, int g, bit chk_idx, bit inject);
    logic [2:0] ph_seen;
    check((ph == PH_RESID) ? "R4 resid phase" : "R3 phase order", longint'(phase_o), longint'(ph));
    check("R5 req next cycle", longint'(req_o), 1);
    if (chk_idx) begin
      check("R6 pixel index", longint'(pix_o), longint'(p));
      check("R7 group index", longint'(grp_o), longint'(g));
    end
    if (ph == PH_CONV) begin
      check("R1 kernel size", longint'(ksize_o), longint'(v.ks));
      check("R1 in channels", longint'(in_ch_o), longint'(1) << v.ic);
      check("R1 weight base", longint'(wbase_o), longint'(v.wb));
      check("R1 strides", longint'({s1_o, s2_o}), longint'({v.s1, v.s2}));
    end
    if (ph == PH_NORM)
      check("R8 norm address", longint'(bn_addr_o), longint'(16'(v.bb + 16'(g))));
    ph_seen = phase_o;
    for (int d = 0; d < int'(v.dly); d++) begin
      if (inject && d == 0) begin
        start_i = 1'b1;
        instr_i = ~instr_i;
      end
      @(negedge clk);
      start_i = 1'b0;
      check("R5 req held", longint'({req_o, phase_o}), longint'({1'b1, ph_seen}));
      if (inject && d == 0)
        check("R2 start ignored", longint'({wbase_o, ksize_o}), longint'({v.wb, v.ks}));
    end
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
  endtask

  task automatic run_vec(vec_t v);
    int s1e, dim, ng;
    bit first;
    s1e = (v.s1 == 0) ? 1 : int'(v.s1);
    dim = (1 << v.hw) / s1e;
    if (dim == 0) dim = 1;
    ng  = (v.oc < 6) ? 1 : (1 << (v.oc - 6));
    first = 1'b1;
    @(negedge clk);
    instr_i = {v.bb, v.wb, v.s2, v.s1, v.oc, v.ic, v.hw, v.ks, v.op};
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R1 busy after start", longint'(busy_o), 1);
    for (int p = 0; p < dim * dim; p++) begin
      for (int g = 0; g < ng; g++) begin
        handshake(v, PH_CLEAR, p, g, 1'b1, v.bst && first);
        first = 1'b0;
        handshake(v, PH_CONV, p, g, 1'b1, 1'b0);
        if (v.op == 2'b01) handshake(v, PH_RESID, p, g, 1'b1, 1'b0);
        handshake(v, PH_NORM, p, g, 1'b1, 1'b0);
        handshake(v, PH_BIN, p, g, 1'b1, 1'b0);
        handshake(v, PH_STORE, p, g, 1'b1, 1'b0);
      end
    end
    handshake(v, PH_SWAP, 0, 0, 1'b0, 1'b0);
    check("R9 done pulse", longint'({done_o, busy_o, req_o}), longint'(3'b100));
    @(negedge clk);
    check("R9 done one cycle", longint'(done_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: idle after reset
    check("R10 reset state", longint'({busy_o, req_o, done_o}), 0);

    for (int i = 0; i < NV; i++) run_vec(TBL[i]);

    // R10: reset in the middle of a layer
    @(negedge clk);
    instr_i = {16'h0, 16'h0, 2'd1, 2'd1, 4'd7, 4'd1, 3'd2, 4'd1, 2'b01};
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    ack_i = 1'b1;
    repeat (3) @(negedge clk);
    ack_i = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 mid-layer reset", longint'({busy_o, req_o, done_o}), 0);

    // R6/R7 after reset: a fresh layer starts at pixel 0, group 0
    run_vec(TBL[0]);

    summary();
    $finish;
  end

endmodule